// File: doc/BRIEF.md
# Low-power mode and module-stop controller

This block decides the power state of a small processor subsystem and drives the clock enables derived from it. A one-cycle sleep strobe from the CPU takes the subsystem out of the run state. A control bit picks the target. With the bit clear, the CPU and the debug break unit halt but the clock generator and the peripherals keep running. With the bit set, everything halts and external memory is put into self-refresh. A wake-up interrupt returns the subsystem to run on the next clock edge. A manual reset also returns it to run. A power-on reset, whatever its source, does the same.

A per-module stop register lets software halt single peripherals while the CPU keeps running. One module position uses the opposite polarity: it stops when its bit is 0. The block also combines the power-on reset sources into one reset pulse and keeps a sticky record of which sources fired. The clock-enable outputs come straight from flip-flops, so a downstream clock gate only sees them change just after an edge.

Top module: `lpc_ctrl`

## Requirements
- R1: In run, with `irq` low, a `sleep_req` pulse with `deep_sel`=0 moves the controller to sleep (`pwr_state`=01) at that clock edge. In sleep, `cpu_clk_en`=0 and `brk_clk_en`=0, while `cpg_en`=1 and module enables still follow the stop bits.
- R2: In run, with `irq` low, a `sleep_req` pulse with `deep_sel`=1 moves the controller to standby (`pwr_state`=10). In standby, `cpg_en`, `cpu_clk_en`, `brk_clk_en` and every bit of `mod_clk_en` are 0.
- R3: `mem_self_refresh` is 1 exactly while the state is standby. In run and sleep it is 0, which selects auto-refresh.
- R4: In sleep or standby, `irq`=1 at a clock edge returns the controller to run (`pwr_state`=00) at that edge, with all enables restored. The stop register keeps its contents across the low-power period.
- R5: A `sleep_req` has no effect when `irq` is high in the same cycle. A `sleep_req` that arrives while already in sleep or standby also has no effect.
- R6: `stop_we` loads `stop_wdata` into the stop register. Module i is enabled when bit i is 0, except at position `INV_POS` (default 4), where the module is enabled when the bit is 1.
- R7: The pin reset and the internal power-on reset both set the stop register to the all-running value (only bit `INV_POS` set). A stop write in the same cycle as an internal power-on reset is dropped.
- R8: The internal power-on reset is raised by `dbg_rst_req`, or by `wdt_ovf` when `wdt_tmode`=1 and `wdt_rsel`=0. `sys_por` is 1 during the pin reset and in the cycle after each internal power-on reset.
- R9: `rst_cause` has bit 0 for the pin reset, bit 1 for the debug request and bit 2 for a qualified watchdog overflow. The pin reset loads 001. Bits are sticky. `cause_clr` clears them, but a new cause in the same cycle wins.
- R10: An internal power-on reset forces the run state from any state.
- R11: `man_rst` forces the run state but keeps the stop register. It does not touch `rst_cause` and does not raise `sys_por`.
- R12: All enable outputs are registered. No module enable is ever high while the state is standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset pin, active low, asynchronous |
| sleep_req | input | 1 | Sleep instruction strobe |
| deep_sel | input | 1 | Selects standby (1) or sleep (0) as the target of `sleep_req` |
| stop_we | input | 1 | Write strobe for the stop register |
| stop_wdata | input | NMOD | New stop register value |
| irq | input | 1 | Wake-up interrupt request |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| dbg_rst_req | input | 1 | Debug-port reset request |
| wdt_ovf | input | 1 | Watchdog overflow |
| wdt_tmode | input | 1 | Watchdog timer-mode bit |
| wdt_rsel | input | 1 | Watchdog reset-select bit |
| cause_clr | input | 1 | Clears the reset cause field |
| pwr_state | output | 2 | 00 run, 01 sleep, 10 standby |
| cpg_en | output | 1 | Clock generator run enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| brk_clk_en | output | 1 | Debug break unit clock enable |
| mod_clk_en | output | NMOD | Per-module clock enables |
| mem_self_refresh | output | 1 | 1 = self-refresh, 0 = auto-refresh |
| sys_por | output | 1 | Internal power-on reset pulse |
| rst_cause | output | 3 | Sticky power-on reset causes |

## Verification
The bench targets the following corner cases:

- **Strobe and interrupt in the same cycle.** A design that lets the strobe win would drop into sleep while an interrupt is pending.
- **Sleep strobe while already asleep.** A design that ignores the state would jump from sleep to standby.
- **The inverted-polarity module.** A design without the inversion would stop that module after reset and run it when asked to stop.
- **Watchdog overflow with the wrong mode bits.** A design that ignores the bits would reset the subsystem falsely.
- **Reset and stop write together.** A design with the wrong priority would leave modules stopped after a reset.
- **Manual reset.** A design that treats it like a power-on reset would lose the stop bits and the cause record.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [1:0] {
    PS_RUN   = 2'b00,
    PS_SLEEP = 2'b01,
    PS_STBY  = 2'b10
  } pstate_e;

  localparam int CAUSE_W   = 3;
  localparam int CAUSE_PIN = 0;
  localparam int CAUSE_DBG = 1;
  localparam int CAUSE_WDT = 2;

  // watchdog overflow is a reset source only in timer mode with reset-select clear
  function automatic logic wdt_counts(input logic tmode, input logic rsel);
    return tmode & ~rsel;
  endfunction

  // state step without resets applied
  function automatic pstate_e step_state(input pstate_e cur, input logic slp,
                                         input logic deep, input logic wake);
    pstate_e nx;
    nx = cur;
    case (cur)
      PS_RUN:   if (slp && !wake) nx = deep ? PS_STBY : PS_SLEEP;
      PS_SLEEP: if (wake) nx = PS_RUN;
      PS_STBY:  if (wake) nx = PS_RUN;
      default:  nx = PS_RUN;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/lpc_reset_src.sv
module lpc_reset_src
  import lpc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dbg_rst_req,
  input  logic               wdt_ovf,
  input  logic               wdt_tmode,
  input  logic               wdt_rsel,
  input  logic               cause_clr,
  output logic               por_hit,
  output logic               sys_por,
  output logic [CAUSE_W-1:0] rst_cause
);

  logic               wdt_hit;
  logic [CAUSE_W-1:0] cause_set;
  logic [CAUSE_W-1:0] cause_q;

  assign wdt_hit = wdt_ovf & wdt_counts(wdt_tmode, wdt_rsel);
  assign por_hit = dbg_rst_req | wdt_hit;

  always_comb begin
    cause_set            = '0;
    cause_set[CAUSE_DBG] = dbg_rst_req;
    cause_set[CAUSE_WDT] = wdt_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q            <= '0;
      cause_q[CAUSE_PIN] <= 1'b1;
      sys_por            <= 1'b1;
    end else begin
      cause_q <= (cause_clr ? '0 : cause_q) | cause_set;
      sys_por <= por_hit;
    end
  end

  assign rst_cause = cause_q;

  // R9: the debug request is always recorded
  a_r9_dbg_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_rst_req |=> rst_cause[CAUSE_DBG]);

  // R8: an unqualified watchdog overflow leaves the cause field and reset alone
  a_r8_wdt_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_ovf && !(wdt_tmode && !wdt_rsel) && !dbg_rst_req && !cause_clr)
      |=> ($stable(rst_cause) && !sys_por));

endmodule

// File: rtl/lpc_mode_fsm.sv
module lpc_mode_fsm
  import lpc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sleep_req,
  input  logic    deep_sel,
  input  logic    irq,
  input  logic    man_rst,
  input  logic    por_hit,
  output pstate_e state_q,
  output pstate_e state_nx
);

  always_comb begin
    if (por_hit || man_rst) state_nx = PS_RUN;
    else                    state_nx = step_state(state_q, sleep_req, deep_sel, irq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_RUN;
    else        state_q <= state_nx;
  end

  // R4: wake-up in one cycle
  a_r4_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PS_RUN && irq) |=> state_q == PS_RUN);

  // R5: pending interrupt blocks the sleep strobe
  a_r5_irq_blocks_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RUN && sleep_req && irq) |=> state_q == PS_RUN);

  // R5: a strobe while asleep does not change the low-power flavour
  a_r5_no_restep: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SLEEP && !irq && !man_rst && !por_hit) |=> state_q == PS_SLEEP);

  // R10: power-on reset forces run
  a_r10_por_run: assert property (@(posedge clk) disable iff (!rst_n)
    por_hit |=> state_q == PS_RUN);

endmodule

// File: rtl/lpc_clk_gate.sv
module lpc_clk_gate
  import lpc_pkg::*;
#(
  parameter int NMOD    = 8,
  parameter int INV_POS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            por_hit,
  input  logic            stop_we,
  input  logic [NMOD-1:0] stop_wdata,
  input  pstate_e         state_q,
  input  pstate_e         state_nx,
  output logic            cpg_en,
  output logic            cpu_clk_en,
  output logic            brk_clk_en,
  output logic [NMOD-1:0] mod_clk_en,
  output logic            mem_self_refresh
);

  localparam logic [NMOD-1:0] RUN_VAL = NMOD'(1) << INV_POS;

  logic [NMOD-1:0] stop_q;
  logic [NMOD-1:0] stop_nx;
  logic [NMOD-1:0] mod_run;
  logic            nx_stby;

  always_comb begin
    if (por_hit)      stop_nx = RUN_VAL;
    else if (stop_we) stop_nx = stop_wdata;
    else              stop_nx = stop_q;
  end

  assign nx_stby = (state_nx == PS_STBY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= RUN_VAL;
    else        stop_q <= stop_nx;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NMOD; gi++) begin : g_mod
      if (gi == INV_POS) begin : g_inv
        assign mod_run[gi] = stop_nx[gi];
      end else begin : g_norm
        assign mod_run[gi] = ~stop_nx[gi];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mod_clk_en[gi] <= 1'b1;
        else        mod_clk_en[gi] <= mod_run[gi] & ~nx_stby;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpg_en           <= 1'b1;
      cpu_clk_en       <= 1'b1;
      brk_clk_en       <= 1'b1;
      mem_self_refresh <= 1'b0;
    end else begin
      cpg_en           <= ~nx_stby;
      cpu_clk_en       <= (state_nx == PS_RUN);
      brk_clk_en       <= (state_nx == PS_RUN);
      mem_self_refresh <= nx_stby;
    end
  end

  // R12: nothing runs in standby
  a_r12_stby_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_STBY) |-> (mod_clk_en == '0 && !cpg_en && !cpu_clk_en));

  // R3: refresh style follows the state register
  a_r3_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    mem_self_refresh == (state_q == PS_STBY));

  // R1: CPU clock only in run
  a_r1_cpu_run: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en == (state_q == PS_RUN));

  // R7: after a power-on reset every module runs
  a_r7_por_release: assert property (@(posedge clk) disable iff (!rst_n)
    por_hit |=> mod_clk_en == {NMOD{1'b1}});

endmodule

// File: rtl/lpc_ctrl.sv
module lpc_ctrl
  import lpc_pkg::*;
#(
  parameter int NMOD    = 8,
  parameter int INV_POS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_req,
  input  logic               deep_sel,
  input  logic               stop_we,
  input  logic [NMOD-1:0]    stop_wdata,
  input  logic               irq,
  input  logic               man_rst,
  input  logic               dbg_rst_req,
  input  logic               wdt_ovf,
  input  logic               wdt_tmode,
  input  logic               wdt_rsel,
  input  logic               cause_clr,
  output logic [1:0]         pwr_state,
  output logic               cpg_en,
  output logic               cpu_clk_en,
  output logic               brk_clk_en,
  output logic [NMOD-1:0]    mod_clk_en,
  output logic               mem_self_refresh,
  output logic               sys_por,
  output logic [CAUSE_W-1:0] rst_cause
);

  logic    por_hit;
  pstate_e state_q;
  pstate_e state_nx;

  lpc_reset_src u_rsrc (
    .clk         (clk),
    .rst_n       (rst_n),
    .dbg_rst_req (dbg_rst_req),
    .wdt_ovf     (wdt_ovf),
    .wdt_tmode   (wdt_tmode),
    .wdt_rsel    (wdt_rsel),
    .cause_clr   (cause_clr),
    .por_hit     (por_hit),
    .sys_por     (sys_por),
    .rst_cause   (rst_cause)
  );

  lpc_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .deep_sel  (deep_sel),
    .irq       (irq),
    .man_rst   (man_rst),
    .por_hit   (por_hit),
    .state_q   (state_q),
    .state_nx  (state_nx)
  );

  lpc_clk_gate #(.NMOD(NMOD), .INV_POS(INV_POS)) u_gate (
    .clk              (clk),
    .rst_n            (rst_n),
    .por_hit          (por_hit),
    .stop_we          (stop_we),
    .stop_wdata       (stop_wdata),
    .state_q          (state_q),
    .state_nx         (state_nx),
    .cpg_en           (cpg_en),
    .cpu_clk_en       (cpu_clk_en),
    .brk_clk_en       (brk_clk_en),
    .mod_clk_en       (mod_clk_en),
    .mem_self_refresh (mem_self_refresh)
  );

  assign pwr_state = state_q;

  // R11: a manual reset alone never raises the power-on pulse
  a_r11_man_no_por: assert property (@(posedge clk) disable iff (!rst_n)
    (man_rst && !dbg_rst_req && !wdt_ovf) |=> (!sys_por && pwr_state == 2'b00));

endmodule

// File: tb/lpc_ctrl_bench.sv
module lpc_ctrl_bench;
  localparam int CLK_P   = 10;
  localparam int NMOD    = 8;
  localparam int INV_POS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req, deep_sel, stop_we, irq, man_rst, dbg_rst_req;
  logic wdt_ovf, wdt_tmode, wdt_rsel, cause_clr;
  logic [NMOD-1:0] stop_wdata;
  logic [1:0] pwr_state;
  logic cpg_en, cpu_clk_en, brk_clk_en, mem_self_refresh, sys_por;
  logic [NMOD-1:0] mod_clk_en;
  logic [2:0] rst_cause;

  int checks = 0, errors = 0;
  bit done = 0;

  // model
  int m_st;
  logic [NMOD-1:0] m_stop;
  logic [2:0] m_cause;
  logic m_por;

  lpc_ctrl #(.NMOD(NMOD), .INV_POS(INV_POS)) u_lpc_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .deep_sel(deep_sel),
    .stop_we(stop_we), .stop_wdata(stop_wdata), .irq(irq), .man_rst(man_rst),
    .dbg_rst_req(dbg_rst_req), .wdt_ovf(wdt_ovf), .wdt_tmode(wdt_tmode),
    .wdt_rsel(wdt_rsel), .cause_clr(cause_clr), .pwr_state(pwr_state),
    .cpg_en(cpg_en), .cpu_clk_en(cpu_clk_en), .brk_clk_en(brk_clk_en),
    .mod_clk_en(mod_clk_en), .mem_self_refresh(mem_self_refresh),
    .sys_por(sys_por), .rst_cause(rst_cause)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [NMOD-1:0] exp_mod(input int st, input logic [NMOD-1:0] stop);
    logic [NMOD-1:0] r;
    r = '0;
    if (st != 2) begin
      for (int i = 0; i < NMOD; i++) begin
        if (i == INV_POS) r[i] = (stop[i] == 1'b1);
        else              r[i] = (stop[i] == 1'b0);
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 state",   32'(pwr_state),        32'(m_st));
    chk("R1 cpu",     32'(cpu_clk_en),       32'(m_st == 0));
    chk("R1 brk",     32'(brk_clk_en),       32'(m_st == 0));
    chk("R2 cpg",     32'(cpg_en),           32'(m_st != 2));
    chk("R6 mod",     32'(mod_clk_en),       32'(exp_mod(m_st, m_stop)));
    chk("R3 refresh", 32'(mem_self_refresh), 32'(m_st == 2));
    chk("R9 cause",   32'(rst_cause),        32'(m_cause));
    chk("R8 por",     32'(sys_por),          32'(m_por));
  endtask

  task automatic clear_in();
    sleep_req = 0; deep_sel = 0; stop_we = 0; stop_wdata = '0; irq = 0;
    man_rst = 0; dbg_rst_req = 0; wdt_ovf = 0; wdt_tmode = 0; wdt_rsel = 0;
    cause_clr = 0;
  endtask

  task automatic tick();
    logic qual, por;
    logic [2:0] set;
    @(posedge clk);
    qual = wdt_ovf && wdt_tmode && !wdt_rsel;
    por  = dbg_rst_req || qual;
    set  = {qual, dbg_rst_req, 1'b0};
    if (por || man_rst) m_st = 0;
    else if (m_st == 0) begin
      if (sleep_req && !irq) m_st = deep_sel ? 2 : 1;
    end else if (irq) m_st = 0;
    if (por) m_stop = NMOD'(1) << INV_POS;
    else if (stop_we) m_stop = stop_wdata;
    m_cause = (cause_clr ? 3'b000 : m_cause) | set;
    m_por = por;
    @(negedge clk);
    compare_all();
    clear_in();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_in();
    m_st = 0; m_stop = NMOD'(1) << INV_POS; m_cause = 3'b001; m_por = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state (R7, R9)
    compare_all();
    chk("R7 reset all run", 32'(mod_clk_en), 32'(8'hFF));
    chk("R9 pin cause", 32'(rst_cause), 32'(3'b001));
    tick();
    // R1 sleep
    sleep_req = 1; tick();
    chk("R1 sleep state", 32'(pwr_state), 32'(2'b01));
    // R5 strobe while asleep ignored
    sleep_req = 1; deep_sel = 1; tick();
    chk("R5 no restep", 32'(pwr_state), 32'(2'b01));
    // R4 wake
    irq = 1; tick();
    chk("R4 wake", 32'(pwr_state), 32'(2'b00));
    // R5 strobe with irq pending
    sleep_req = 1; irq = 1; tick();
    chk("R5 irq blocks", 32'(pwr_state), 32'(2'b00));
    // R6 stop bits and inverted position
    stop_we = 1; stop_wdata = 8'h05; tick();
    chk("R6 stop 05", 32'(mod_clk_en), 32'(8'hEA));
    stop_we = 1; stop_wdata = 8'h00; tick();
    chk("R6 inverted stop", 32'(mod_clk_en), 32'(8'hEF));
    stop_we = 1; stop_wdata = 8'h05; tick();
    // R2 / R12 standby
    sleep_req = 1; deep_sel = 1; tick();
    chk("R2 standby mods", 32'(mod_clk_en), 32'(0));
    chk("R12 standby cpg", 32'(cpg_en), 32'(0));
    chk("R3 self refresh", 32'(mem_self_refresh), 32'(1));
    tick();
    irq = 1; tick();
    chk("R4 stop retained", 32'(mod_clk_en), 32'(8'hEA));
    // R11 manual reset
    sleep_req = 1; tick();
    man_rst = 1; tick();
    chk("R11 man run", 32'(pwr_state), 32'(2'b00));
    chk("R11 stop kept", 32'(mod_clk_en), 32'(8'hEA));
    chk("R11 no por", 32'(sys_por), 32'(0));
    // R8 watchdog qualification
    sleep_req = 1; tick();
    wdt_ovf = 1; wdt_tmode = 0; wdt_rsel = 0; tick();
    chk("R8 wdt tmode0", 32'(sys_por), 32'(0));
    wdt_ovf = 1; wdt_tmode = 1; wdt_rsel = 1; tick();
    chk("R8 wdt rsel1", 32'(pwr_state), 32'(2'b01));
    wdt_ovf = 1; wdt_tmode = 1; wdt_rsel = 0; stop_we = 1; stop_wdata = 8'hFF; tick();
    chk("R8 wdt por", 32'(sys_por), 32'(1));
    chk("R9 wdt cause", 32'(rst_cause), 32'(3'b101));
    chk("R10 por run", 32'(pwr_state), 32'(2'b00));
    chk("R7 write dropped", 32'(mod_clk_en), 32'(8'hFF));
    cause_clr = 1; tick();
    chk("R9 cleared", 32'(rst_cause), 32'(0));
    dbg_rst_req = 1; cause_clr = 1; tick();
    chk("R9 set wins", 32'(rst_cause), 32'(3'b010));
    // random
    for (int n = 0; n < 3000; n++) begin
      sleep_req   = ($urandom % 4) == 0;
      deep_sel    = $urandom % 2;
      irq         = ($urandom % 8) == 0;
      stop_we     = ($urandom % 8) == 0;
      stop_wdata  = NMOD'($urandom);
      man_rst     = ($urandom % 32) == 0;
      dbg_rst_req = ($urandom % 64) == 0;
      wdt_ovf     = ($urandom % 16) == 0;
      wdt_tmode   = $urandom % 2;
      wdt_rsel    = $urandom % 2;
      cause_clr   = ($urandom % 16) == 0;
      tick();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule